// File: doc/BRIEF.md
# Power-Management Event Register Block

This block holds the event and control state of a power-management I/O window. The state is a 16-bit event status word with a matching 16-bit enable word, a 16-bit control word, a bank of general-purpose event bytes (eight status bytes followed by eight enable bytes) and a 32-bit SMI enable word. Hardware events set status bits. Software clears a status bit by writing a one to it. A level interrupt line, the system control interrupt (SCI), is high whenever one of four specific status sources is both pending and enabled. A second output reports when the next timer-overflow wake-up is armed.

The register window is 128 bytes. It sits wherever the base-address input places it. Decode is off while that base is zero or not aligned to 128 bytes. Software can issue byte, word or dword accesses, and the byte order is little-endian. An access that has no register of its own width at its offset is split into smaller pieces at consecutive addresses: a dword becomes two words and a word becomes two bytes. Read data returns one cycle after the request.

Top module: `pm_evt_block`

## Requirements
- R1: The block decodes a request only when `base_addr` is nonzero, its low 7 bits are zero, and `req_addr[15:7]` equals `base_addr[15:7]`. Any other request reads as zero and its writes change nothing.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. `rsp_rdata` carries the read data in that cycle and is zero otherwise and for writes.
- R3: The event status word is at offset 0x00 (word). Its bits are timer 0, global-lock 5, power-button 8, auxiliary 9 and RTC alarm 10. Each bit is set by its event input and cleared by writing a one to it. Writing a zero leaves the bit unchanged. An event wins over a clear in the same cycle.
- R4: The event enable word at offset 0x02 and the control word at offset 0x04 are plain 16-bit read/write registers reached by word access.
- R5: `sci` is high if and only if status and enable are both set for at least one of bits 0, 5, 8 and 10. Bit 9 never raises it. `sci` follows the register state from the clock edge that changes it.
- R6: `tmr_arm` is high exactly when enable bit 0 is set and status bit 0 is clear.
- R7: Byte access reaches only offsets 0x20-0x2F. The status bytes are at 0x20-0x27: bit b of byte i is set by `gpe_evt[8*i+b]` and cleared by writing a one to it. The enable bytes are at 0x28-0x2F and are read/write. A byte access to any other offset reads zero and its write is ignored. These bytes never affect `sci`.
- R8: The 32-bit SMI enable register is at offset 0x30. Only dword access reaches it. Word and byte accesses there read zero and are ignored.
- R9: A dword access at an offset other than 0x30 is handled as two word accesses, at the offset (bits 15:0) and at the offset plus 2 (bits 31:16). A word access at an offset other than 0x00, 0x02 or 0x04 is handled as two byte accesses, at the offset (bits 7:0) and at the offset plus 1 (bits 15:8). `req_size` encodes 0 as byte, 1 as word and 2 as dword. Encoding 3 is a no-op.
- R10: After reset, every register reads zero and `sci`, `tmr_arm` and `rsp_valid` are low.
- R11: A `pwrbtn_req` pulse sets status bit 8. This raises `sci` if enable bit 8 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_addr | input | 16 | Window base address; zero disables decode |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2 dword |
| req_addr | input | 16 | Access address |
| req_wdata | input | 32 | Write data, little-endian lanes |
| tmr_ovf | input | 1 | Timer overflow tick (status bit 0) |
| pwrbtn_req | input | 1 | Power-down request (status bit 8) |
| rtc_alarm | input | 1 | RTC alarm event (status bit 10) |
| gbl_rls | input | 1 | Global-lock release event (status bit 5) |
| aux_evt | input | 1 | Auxiliary event (status bit 9, not an SCI source) |
| gpe_evt | input | 64 | General-purpose event set pulses |
| rsp_valid | output | 1 | Read/response valid, one cycle after request |
| rsp_rdata | output | 32 | Read data |
| sci | output | 1 | System control interrupt level |
| tmr_arm | output | 1 | Timer wake-up armed |

## Verification
The hardest situation to create from the ports is a single request that touches several register kinds at once through splitting. Examples are a dword that straddles the enable and control words, a word that lands on two enable bytes of the event bank, and a misaligned word that splits into two dead bytes. The stimulus table programs distinct byte patterns into each register first, so that every lane of a split read can be traced to its source. A second hard case is an event arriving in the same cycle as a write-one-to-clear of the same bit. The bench drives the event pulse and the write request together, on the same falling edge.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;

  localparam int WIN_W     = 7;
  localparam int BUS_BYTES = 4;
  localparam int BUS_W     = BUS_BYTES * 8;
  localparam int EVT_W     = 16;
  localparam int GPE_IDX_W = 4;
  localparam int GPE_BYTES = 1 << GPE_IDX_W;
  localparam int GPE_HALF  = GPE_BYTES / 2;
  localparam int GPE_EVT_W = GPE_HALF * 8;

  localparam logic [WIN_W-1:0] OFF_STS = 7'h00;
  localparam logic [WIN_W-1:0] OFF_EN  = 7'h02;
  localparam logic [WIN_W-1:0] OFF_CNT = 7'h04;
  localparam logic [WIN_W-1:0] OFF_GPE = 7'h20;
  localparam logic [WIN_W-1:0] OFF_SMI = 7'h30;

  localparam logic [1:0] SZ_BYTE  = 2'd0;
  localparam logic [1:0] SZ_WORD  = 2'd1;
  localparam logic [1:0] SZ_DWORD = 2'd2;

  localparam int BIT_TMR    = 0;
  localparam int BIT_GBL    = 5;
  localparam int BIT_PWRBTN = 8;
  localparam int BIT_AUX    = 9;
  localparam int BIT_RTC    = 10;

  localparam logic [EVT_W-1:0] SCI_MASK =
    EVT_W'((1 << BIT_TMR) | (1 << BIT_GBL) | (1 << BIT_PWRBTN) | (1 << BIT_RTC));

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_STS,
    TGT_EN,
    TGT_CNT,
    TGT_GPE,
    TGT_SMI
  } tgt_e;

  typedef struct packed {
    tgt_e                 tgt;
    logic [GPE_IDX_W-1:0] idx;
  } lane_t;

  localparam lane_t LANE_NONE = '{tgt: TGT_NONE, idx: '0};

  // A single byte: only the event bank answers.
  function automatic lane_t byte_target(input logic [WIN_W-1:0] off);
    lane_t r;
    r = LANE_NONE;
    if (off[WIN_W-1:GPE_IDX_W] == OFF_GPE[WIN_W-1:GPE_IDX_W]) begin
      r.tgt = TGT_GPE;
      r.idx = off[GPE_IDX_W-1:0];
    end
    return r;
  endfunction

  // A word: a word register if one sits there, else two bytes.
  function automatic lane_t word_target(input logic [WIN_W-1:0] woff,
                                        input logic hi);
    lane_t r;
    r = LANE_NONE;
    if (woff == OFF_STS) begin
      r.tgt = TGT_STS; r.idx = {{(GPE_IDX_W-1){1'b0}}, hi};
    end else if (woff == OFF_EN) begin
      r.tgt = TGT_EN;  r.idx = {{(GPE_IDX_W-1){1'b0}}, hi};
    end else if (woff == OFF_CNT) begin
      r.tgt = TGT_CNT; r.idx = {{(GPE_IDX_W-1){1'b0}}, hi};
    end else begin
      r = byte_target(woff + {{(WIN_W-1){1'b0}}, hi});
    end
    return r;
  endfunction

  // Resolve one bus lane of one access to a register byte.
  function automatic lane_t lane_map(input logic [WIN_W-1:0] off,
                                     input logic [1:0] size,
                                     input logic [1:0] lane);
    lane_t r;
    r = LANE_NONE;
    case (size)
      SZ_BYTE:  if (lane == 2'd0) r = byte_target(off);
      SZ_WORD:  if (!lane[1]) r = word_target(off, lane[0]);
      SZ_DWORD: begin
        if (off == OFF_SMI) begin
          r.tgt = TGT_SMI;
          r.idx = {{(GPE_IDX_W-2){1'b0}}, lane};
        end else begin
          r = word_target(off + {{(WIN_W-2){1'b0}}, lane[1], 1'b0}, lane[0]);
        end
      end
      default: r = LANE_NONE;
    endcase
    return r;
  endfunction

  function automatic logic sci_level(input logic [EVT_W-1:0] sts,
                                     input logic [EVT_W-1:0] en);
    return |(sts & en & SCI_MASK);
  endfunction

  function automatic logic timer_armed(input logic [EVT_W-1:0] sts,
                                       input logic [EVT_W-1:0] en);
    return en[BIT_TMR] & ~sts[BIT_TMR];
  endfunction

endpackage

// File: rtl/pm_win_decode.sv
module pm_win_decode
  import pm_evt_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0]           base_addr,
  input  logic                        req_valid,
  input  logic [1:0]                  req_size,
  input  logic [ADDR_W-1:0]           req_addr,
  output logic                        hit,
  output lane_t [BUS_BYTES-1:0]       lanes
);

  logic             base_ok;
  logic [WIN_W-1:0] off;

  assign base_ok = (base_addr != '0) && (base_addr[WIN_W-1:0] == '0);
  assign off     = req_addr[WIN_W-1:0];
  assign hit     = req_valid && base_ok &&
                   (req_addr[ADDR_W-1:WIN_W] == base_addr[ADDR_W-1:WIN_W]);

  for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
    assign lanes[i] = lane_map(off, req_size, 2'(i));
  end

endmodule

// File: rtl/pm1_evt_regs.sv
module pm1_evt_regs
  import pm_evt_pkg::*;
#(
  parameter int W = EVT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [W-1:0]       sts_set,
  input  logic [W-1:0]       sts_clr,
  input  logic [W/8-1:0]     en_be,
  input  logic [W-1:0]       en_wd,
  input  logic [W/8-1:0]     cnt_be,
  input  logic [W-1:0]       cnt_wd,
  output logic [W-1:0]       sts,
  output logic [W-1:0]       en,
  output logic [W-1:0]       cnt
);

  localparam int NB = W / 8;

  always_ff @(posedge clk) begin
    if (!rst_n) sts <= '0;
    else        sts <= (sts & ~sts_clr) | sts_set;
  end

  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en[b*8 +: 8]  <= '0;
        cnt[b*8 +: 8] <= '0;
      end else begin
        if (en_be[b])  en[b*8 +: 8]  <= en_wd[b*8 +: 8];
        if (cnt_be[b]) cnt[b*8 +: 8] <= cnt_wd[b*8 +: 8];
      end
    end
  end

endmodule

// File: rtl/pm_gpe_bank.sv
module pm_gpe_bank
  import pm_evt_pkg::*;
#(
  parameter int HALF = GPE_HALF
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [HALF*8-1:0]            evt,
  input  logic [2*HALF-1:0]            we,
  input  logic [2*HALF-1:0][7:0]       wd,
  output logic [2*HALF-1:0][7:0]       q
);

  for (genvar i = 0; i < 2*HALF; i++) begin : g_byte
    if (i < HALF) begin : g_sts
      logic [7:0] clr;
      assign clr = we[i] ? wd[i] : 8'h00;
      always_ff @(posedge clk) begin
        if (!rst_n) q[i] <= '0;
        else        q[i] <= (q[i] & ~clr) | evt[i*8 +: 8];
      end
    end else begin : g_en
      always_ff @(posedge clk) begin
        if (!rst_n)     q[i] <= '0;
        else if (we[i]) q[i] <= wd[i];
      end
    end
  end

endmodule

// File: rtl/pm_evt_block.sv
module pm_evt_block
  import pm_evt_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    base_addr,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [1:0]           req_size,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [BUS_W-1:0]     req_wdata,
  input  logic                 tmr_ovf,
  input  logic                 pwrbtn_req,
  input  logic                 rtc_alarm,
  input  logic                 gbl_rls,
  input  logic                 aux_evt,
  input  logic [GPE_EVT_W-1:0] gpe_evt,
  output logic                 rsp_valid,
  output logic [BUS_W-1:0]     rsp_rdata,
  output logic                 sci,
  output logic                 tmr_arm
);

  logic                        hit;
  lane_t [BUS_BYTES-1:0]       lanes;
  logic                        wr_hit;
  logic                        rd_hit;

  logic [EVT_W-1:0]            pm1_sts;
  logic [EVT_W-1:0]            pm1_en;
  logic [EVT_W-1:0]            pm1_cnt;
  logic [EVT_W-1:0]            pm1_set;
  logic [EVT_W-1:0]            sts_clr;
  logic [EVT_W/8-1:0]          en_be;
  logic [EVT_W-1:0]            en_wd;
  logic [EVT_W/8-1:0]          cnt_be;
  logic [EVT_W-1:0]            cnt_wd;

  logic [GPE_BYTES-1:0]        gpe_we;
  logic [GPE_BYTES-1:0][7:0]   gpe_wd;
  logic [GPE_BYTES-1:0][7:0]   gpe_q;

  logic [BUS_W-1:0]            smi_en;
  logic [BUS_BYTES-1:0]        smi_be;
  logic [BUS_W-1:0]            rd_next;

  pm_win_decode #(.ADDR_W(ADDR_W)) u_dec (
    .base_addr (base_addr),
    .req_valid (req_valid),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .hit       (hit),
    .lanes     (lanes)
  );

  assign wr_hit = hit && req_write;
  assign rd_hit = hit && !req_write;

  // Event sources into the status word.
  always_comb begin
    pm1_set             = '0;
    pm1_set[BIT_TMR]    = tmr_ovf;
    pm1_set[BIT_GBL]    = gbl_rls;
    pm1_set[BIT_PWRBTN] = pwrbtn_req;
    pm1_set[BIT_AUX]    = aux_evt;
    pm1_set[BIT_RTC]    = rtc_alarm;
  end

  // Route each write lane to its register byte.
  always_comb begin
    sts_clr = '0;
    en_be   = '0;
    en_wd   = '0;
    cnt_be  = '0;
    cnt_wd  = '0;
    gpe_we  = '0;
    gpe_wd  = '0;
    smi_be  = '0;
    for (int i = 0; i < BUS_BYTES; i++) begin
      if (wr_hit) begin
        case (lanes[i].tgt)
          TGT_STS: sts_clr[lanes[i].idx[0]*8 +: 8] = req_wdata[i*8 +: 8];
          TGT_EN: begin
            en_be[lanes[i].idx[0]]           = 1'b1;
            en_wd[lanes[i].idx[0]*8 +: 8]    = req_wdata[i*8 +: 8];
          end
          TGT_CNT: begin
            cnt_be[lanes[i].idx[0]]          = 1'b1;
            cnt_wd[lanes[i].idx[0]*8 +: 8]   = req_wdata[i*8 +: 8];
          end
          TGT_GPE: begin
            gpe_we[lanes[i].idx]             = 1'b1;
            gpe_wd[lanes[i].idx]             = req_wdata[i*8 +: 8];
          end
          TGT_SMI: smi_be[lanes[i].idx[1:0]] = 1'b1;
          default: ;
        endcase
      end
    end
  end

  pm1_evt_regs #(.W(EVT_W)) u_pm1 (
    .clk     (clk),
    .rst_n   (rst_n),
    .sts_set (pm1_set),
    .sts_clr (sts_clr),
    .en_be   (en_be),
    .en_wd   (en_wd),
    .cnt_be  (cnt_be),
    .cnt_wd  (cnt_wd),
    .sts     (pm1_sts),
    .en      (pm1_en),
    .cnt     (pm1_cnt)
  );

  pm_gpe_bank #(.HALF(GPE_HALF)) u_gpe (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (gpe_evt),
    .we    (gpe_we),
    .wd    (gpe_wd),
    .q     (gpe_q)
  );

  for (genvar b = 0; b < BUS_BYTES; b++) begin : g_smi
    always_ff @(posedge clk) begin
      if (!rst_n)         smi_en[b*8 +: 8] <= '0;
      else if (smi_be[b]) smi_en[b*8 +: 8] <= req_wdata[b*8 +: 8];
    end
  end

  // Gather read lanes.
  always_comb begin
    rd_next = '0;
    for (int i = 0; i < BUS_BYTES; i++) begin
      case (lanes[i].tgt)
        TGT_STS: rd_next[i*8 +: 8] = pm1_sts[lanes[i].idx[0]*8 +: 8];
        TGT_EN:  rd_next[i*8 +: 8] = pm1_en[lanes[i].idx[0]*8 +: 8];
        TGT_CNT: rd_next[i*8 +: 8] = pm1_cnt[lanes[i].idx[0]*8 +: 8];
        TGT_GPE: rd_next[i*8 +: 8] = gpe_q[lanes[i].idx];
        TGT_SMI: rd_next[i*8 +: 8] = smi_en[lanes[i].idx[1:0]*8 +: 8];
        default: rd_next[i*8 +: 8] = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= rd_hit ? rd_next : '0;
    end
  end

  assign sci     = sci_level(pm1_sts, pm1_en);
  assign tmr_arm = timer_armed(pm1_sts, pm1_en);

endmodule

// File: rtl/pm_evt_block_chk.sv
module pm_evt_block_chk
  import pm_evt_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  base_addr,
  input logic               req_valid,
  input logic               req_write,
  input logic [1:0]         req_size,
  input logic               rsp_valid,
  input logic [BUS_W-1:0]   rsp_rdata,
  input logic               sci,
  input logic               tmr_arm,
  input logic               tmr_ovf,
  input logic               pwrbtn_req,
  input logic [EVT_W-1:0]   pm1_sts,
  input logic [EVT_W-1:0]   pm1_en,
  input logic [BUS_W-1:0]   smi_en
);

  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_rsp_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && rsp_rdata == '0);

  assert_base_zero_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && base_addr == '0) |=> rsp_rdata == '0);

  assert_base_zero_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && base_addr == '0) |=> ($stable(smi_en) && $stable(pm1_en)));

  assert_pwrbtn_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pwrbtn_req |=> pm1_sts[BIT_PWRBTN]);

  assert_no_spurious_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwrbtn_req && !pm1_sts[BIT_PWRBTN]) |=> !pm1_sts[BIT_PWRBTN]);

  assert_tick_disarms_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> !tmr_arm);

  assert_sci_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sci |-> (pm1_en & SCI_MASK) != '0);

  assert_sci_needs_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sci |-> (pm1_sts & SCI_MASK) != '0);

  assert_smi_dword_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_size != SZ_DWORD) |=> $stable(smi_en));

endmodule

bind pm_evt_block pm_evt_block_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/pm_evt_block_bench.sv
`timescale 1ns/1ps
module pm_evt_block_bench;

  localparam logic [15:0] BASE_A = 16'h0400;
  localparam logic [15:0] BASE_B = 16'h0800;
  localparam int NV = 28;

  // {write, size, offset, wdata, expected, requirement}
  localparam logic [77:0] VEC [NV] = '{
    {1'b1, 2'd2, 7'h30, 32'hA5C30F12, 32'h0,        4'd8}, // R8 dword write
    {1'b0, 2'd2, 7'h30, 32'h0,        32'hA5C30F12, 4'd8}, // R8 read back
    {1'b0, 2'd1, 7'h30, 32'h0,        32'h0,        4'd8}, // R8 word reads zero
    {1'b1, 2'd1, 7'h30, 32'h0000FFFF, 32'h0,        4'd8}, // R8 word write ignored
    {1'b0, 2'd2, 7'h30, 32'h0,        32'hA5C30F12, 4'd8},
    {1'b1, 2'd0, 7'h30, 32'h000000FF, 32'h0,        4'd8}, // R8 byte write ignored
    {1'b0, 2'd2, 7'h30, 32'h0,        32'hA5C30F12, 4'd8},
    {1'b1, 2'd1, 7'h02, 32'h00000521, 32'h0,        4'd4}, // R4 enable
    {1'b0, 2'd1, 7'h02, 32'h0,        32'h00000521, 4'd4},
    {1'b1, 2'd1, 7'h04, 32'h0000BEEF, 32'h0,        4'd4}, // R4 control
    {1'b0, 2'd1, 7'h04, 32'h0,        32'h0000BEEF, 4'd4},
    {1'b0, 2'd2, 7'h00, 32'h0,        32'h05210000, 4'd9}, // R9 status+enable
    {1'b1, 2'd2, 7'h28, 32'h80402010, 32'h0,        4'd7}, // R7 enable bytes
    {1'b0, 2'd0, 7'h29, 32'h0,        32'h00000020, 4'd7},
    {1'b0, 2'd1, 7'h2A, 32'h0,        32'h00008040, 4'd9}, // R9 word to bytes
    {1'b0, 2'd0, 7'h02, 32'h0,        32'h0,        4'd7}, // R7 byte off-bank
    {1'b1, 2'd0, 7'h04, 32'h000000FF, 32'h0,        4'd7},
    {1'b0, 2'd1, 7'h04, 32'h0,        32'h0000BEEF, 4'd7},
    {1'b1, 2'd2, 7'h04, 32'h12345678, 32'h0,        4'd9}, // R9 dword splits
    {1'b0, 2'd1, 7'h04, 32'h0,        32'h00005678, 4'd9},
    {1'b0, 2'd2, 7'h02, 32'h0,        32'h56780521, 4'd9},
    {1'b1, 2'd1, 7'h2E, 32'h0000CDAB, 32'h0,        4'd9},
    {1'b0, 2'd2, 7'h2C, 32'h0,        32'hCDAB0000, 4'd9},
    {1'b0, 2'd1, 7'h01, 32'h0,        32'h0,        4'd9}, // R9 dead word
    {1'b1, 2'd0, 7'h20, 32'h000000FF, 32'h0,        4'd7}, // R7 W1C no set
    {1'b0, 2'd0, 7'h20, 32'h0,        32'h0,        4'd7},
    {1'b1, 2'd1, 7'h00, 32'h0000FFFF, 32'h0,        4'd3}, // R3 W1C no set
    {1'b0, 2'd1, 7'h00, 32'h0,        32'h0,        4'd3}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] base_addr = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = '0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        tmr_ovf = 1'b0, pwrbtn_req = 1'b0, rtc_alarm = 1'b0;
  logic        gbl_rls = 1'b0, aux_evt = 1'b0;
  logic [63:0] gpe_evt = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        sci, tmr_arm;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pm_evt_block u_pm_evt_block (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .tmr_ovf(tmr_ovf), .pwrbtn_req(pwrbtn_req), .rtc_alarm(rtc_alarm),
    .gbl_rls(gbl_rls), .aux_evt(aux_evt), .gpe_evt(gpe_evt),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sci(sci), .tmr_arm(tmr_arm)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [1:0] sz, input logic [15:0] a,
                     input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    q = rsp_rdata;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: tmr_ovf = 1'b1;
      5: gbl_rls = 1'b1;
      8: pwrbtn_req = 1'b1;
      9: aux_evt = 1'b1;
      default: rtc_alarm = 1'b1;
    endcase
    @(negedge clk);
    tmr_ovf = 1'b0; gbl_rls = 1'b0; pwrbtn_req = 1'b0; aux_evt = 1'b0; rtc_alarm = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] q;
    base_addr = BASE_A;
    do_reset();

    // R10 reset state
    chk("R10 sci", {31'b0, sci}, 32'h0);
    chk("R10 tmr_arm", {31'b0, tmr_arm}, 32'h0);
    chk("R10 rsp_valid", {31'b0, rsp_valid}, 32'h0);
    acc(1'b0, 2'd2, BASE_A + 16'h00, 32'h0, q); chk("R10 status/enable", q, 32'h0);
    acc(1'b0, 2'd2, BASE_A + 16'h30, 32'h0, q); chk("R10 smi", q, 32'h0);
    acc(1'b0, 2'd1, BASE_A + 16'h04, 32'h0, q); chk("R10 control", q, 32'h0);
    chk("R2 rsp_valid after read", {31'b0, rsp_valid}, 32'h1);
    @(negedge clk);
    chk("R2 rsp_valid idle", {31'b0, rsp_valid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic        w;
      logic [1:0]  sz;
      logic [6:0]  off;
      logic [31:0] d, e;
      logic [3:0]  tag;
      {w, sz, off, d, e, tag} = VEC[i];
      acc(w, sz, BASE_A + {9'b0, off}, d, q);
      if (!w) chk($sformatf("R%0d vec %0d", tag, i), q, e);
    end

    // Enable is now 0x0521: timer, global lock, power button, RTC.
    chk("R6 armed", {31'b0, tmr_arm}, 32'h1);
    pulse(0);
    chk("R5 timer sci", {31'b0, sci}, 32'h1);
    chk("R6 disarmed", {31'b0, tmr_arm}, 32'h0);
    acc(1'b1, 2'd1, BASE_A, 32'h0000, q);
    acc(1'b0, 2'd1, BASE_A, 32'h0, q); chk("R3 zero write keeps", q, 32'h0001);
    acc(1'b1, 2'd1, BASE_A, 32'h0001, q);
    chk("R5 cleared sci", {31'b0, sci}, 32'h0);
    chk("R6 rearmed", {31'b0, tmr_arm}, 32'h1);

    acc(1'b1, 2'd1, BASE_A + 16'h02, 32'h0721, q);
    pulse(9);
    chk("R5 aux never sci", {31'b0, sci}, 32'h0);
    acc(1'b0, 2'd1, BASE_A, 32'h0, q); chk("R3 aux status", q, 32'h0200);
    acc(1'b1, 2'd1, BASE_A, 32'h0200, q);

    pulse(8);
    chk("R11 pwrbtn sci", {31'b0, sci}, 32'h1);
    acc(1'b0, 2'd1, BASE_A, 32'h0, q); chk("R11 pwrbtn status", q, 32'h0100);
    acc(1'b1, 2'd1, BASE_A, 32'h0100, q);
    chk("R5 pwrbtn cleared", {31'b0, sci}, 32'h0);

    // R3 event wins over a same-cycle clear
    @(negedge clk);
    pwrbtn_req = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_size = 2'd1; req_addr = BASE_A; req_wdata = 32'h0100;
    @(negedge clk);
    pwrbtn_req = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    acc(1'b0, 2'd1, BASE_A, 32'h0, q); chk("R3 set wins", q, 32'h0100);
    acc(1'b1, 2'd1, BASE_A, 32'h0100, q);

    pulse(10);
    chk("R5 rtc sci", {31'b0, sci}, 32'h1);
    acc(1'b1, 2'd1, BASE_A, 32'h0400, q);
    pulse(5);
    chk("R5 gbl sci", {31'b0, sci}, 32'h1);
    acc(1'b1, 2'd1, BASE_A, 32'h0020, q);
    chk("R5 all clear", {31'b0, sci}, 32'h0);

    // R7 general-purpose status byte
    @(negedge clk); gpe_evt[9] = 1'b1;
    @(negedge clk); gpe_evt = '0;
    chk("R7 gpe no sci", {31'b0, sci}, 32'h0);
    acc(1'b0, 2'd0, BASE_A + 16'h21, 32'h0, q); chk("R7 gpe status", q, 32'h02);
    acc(1'b0, 2'd2, BASE_A + 16'h20, 32'h0, q); chk("R9 gpe dword", q, 32'h0200);
    acc(1'b1, 2'd0, BASE_A + 16'h21, 32'h02, q);
    acc(1'b0, 2'd0, BASE_A + 16'h21, 32'h0, q); chk("R7 gpe cleared", q, 32'h0);

    // R1 relocation and disable
    base_addr = 16'h0000;
    acc(1'b0, 2'd2, 16'h0030, 32'h0, q); chk("R1 base zero read", q, 32'h0);
    acc(1'b1, 2'd2, 16'h0030, 32'h11111111, q);
    base_addr = BASE_A + 16'h0010;
    acc(1'b0, 2'd2, BASE_A + 16'h30, 32'h0, q); chk("R1 misaligned base", q, 32'h0);
    base_addr = BASE_B;
    acc(1'b0, 2'd2, BASE_B + 16'h30, 32'h0, q); chk("R1 moved window", q, 32'hA5C30F12);
    acc(1'b0, 2'd2, BASE_A + 16'h30, 32'h0, q); chk("R1 old window dead", q, 32'h0);

    // R10 reset mid-run
    base_addr = 16'h0000;
    do_reset();
    base_addr = BASE_B;
    chk("R10 sci after reset", {31'b0, sci}, 32'h0);
    chk("R10 tmr_arm after reset", {31'b0, tmr_arm}, 32'h0);
    acc(1'b0, 2'd2, BASE_B + 16'h30, 32'h0, q); chk("R10 smi after reset", q, 32'h0);
    acc(1'b0, 2'd2, BASE_B + 16'h02, 32'h0, q); chk("R10 enable/control", q, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule